// File: doc/BRIEF.md
# Modified NRZI double-data-rate line codec

This block sits between a logical bit stream and a single shared serial data line. One bus clock runs the line, and a bit slot lasts half a clock period, so every clock cycle carries two slots. The slot in the high phase comes first and the slot in the low phase comes second. On the send side a logical one drives the line to the opposite of its last level. A logical zero leaves the line undriven, and an external keeper holds the old level through that slot. The send side produces a drive-enable and a drive-value for each slot.

On the receive side the block samples the line level once per slot, together with an indication of whether any device actually drove that slot. It turns level changes back into ones and no-change slots into zeros. The schedule logic tells the block which slots should carry a driver. The block flags each of those slots that nobody drove, which exposes missing devices and bus faults. Framing, control words and the keeper itself lie outside this block.

Top module: `mnrzi_ddr_codec`

## Requirements
- R1: While reset is low, and after it, the line is not driven and both receive outputs are 0. Both the send and receive reference levels start low, so a one in the first slot after reset drives the line high, and a high level in the first received slot decodes as 1.
- R2: A send bit of 0 leaves `line_oe` low for its slot.
- R3: A send bit of 1 sets `line_oe` high for its slot and drives `line_out` to the inverse of the previous slot's level.
- R4: `line_out` always shows the slot's line level. The send reference is updated in every slot, including undriven ones.
- R5: `tx_bits` is taken at a rising edge. Bit 0 occupies the high phase that follows, and bit 1 occupies the low phase after that.
- R6: The high-phase slot is sampled at the falling edge and the low-phase slot at the next rising edge. At that rising edge `rx_bits[i]` becomes 1 exactly when slot i's level differs from the level of the slot before it.
- R7: At the same rising edge `rx_undriven[i]` becomes 1 exactly when `rx_expect_drv[i]` was 1 and `line_drv_seen` was 0 in slot i.
- R8: A slot that is driven but keeps the old level decodes as 0 and raises no undriven flag.
- R9: The first slot of a cycle is compared against the last slot of the previous cycle, so the receive reference carries across cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges bound slots |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bits | input | 2 | Send bits for the next cycle, bit 0 first |
| line_oe | output | 1 | Drive enable for the current slot |
| line_out | output | 1 | Line level for the current slot |
| line_in | input | 1 | Sampled line level |
| line_drv_seen | input | 1 | 1 when some device drove the current slot |
| rx_expect_drv | input | 2 | Slots of the last cycle that should have been driven, sampled at the rising edge |
| rx_bits | output | 2 | Decoded bits of the last cycle, bit 0 first |
| rx_undriven | output | 2 | Per-slot undriven flags of the last cycle |

## Verification
The send side is swept with every pair of send bits following every reference level. This separates a zero-holds-level fault from an always-toggle fault, and it catches swapped slot order. The receive side is swept over three kinds of slot (undriven, driven with a change, driven with no change), each with and without an expected driver. The driven-no-change case separates decoding by level change from decoding by drive presence. The expected-but-absent case separates the flag from the decoded bit. A reset in the middle of the stream shows that both references return to low.

// File: rtl/mnrzi_pkg.sv
package mnrzi_pkg;
  localparam int SLOTS = 2;
  typedef logic [SLOTS-1:0] slot_vec_t;

  function automatic slot_vec_t enc_levels(input logic ref_lvl, input slot_vec_t bits);
    slot_vec_t lv;
    logic cur;
    cur = ref_lvl;
    for (int i = 0; i < SLOTS; i++) begin
      cur   = cur ^ bits[i];
      lv[i] = cur;
    end
    return lv;
  endfunction

  function automatic slot_vec_t dec_bits(input logic ref_lvl, input slot_vec_t lv);
    slot_vec_t b;
    logic prev;
    prev = ref_lvl;
    for (int i = 0; i < SLOTS; i++) begin
      b[i] = lv[i] ^ prev;
      prev = lv[i];
    end
    return b;
  endfunction

  function automatic slot_vec_t missing_drv(input slot_vec_t expect_v, input slot_vec_t seen);
    return expect_v & ~seen;
  endfunction
endpackage

// File: rtl/mnrzi_tx_enc.sv
module mnrzi_tx_enc
  import mnrzi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slot_vec_t bits,
  output slot_vec_t oe_q,
  output slot_vec_t lvl_q
);
  logic      ref_lvl;
  slot_vec_t next_lvl;

  assign ref_lvl  = lvl_q[SLOTS-1];
  assign next_lvl = enc_levels(ref_lvl, bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= '0;
      lvl_q <= '0;
    end else begin
      oe_q  <= bits;
      lvl_q <= next_lvl;
    end
  end
endmodule

// File: rtl/mnrzi_ddr_out.sv
module mnrzi_ddr_out
  import mnrzi_pkg::*;
(
  input  logic      clk,
  input  slot_vec_t oe_pair,
  input  slot_vec_t lvl_pair,
  output logic      line_oe,
  output logic      line_out
);
  assign line_oe  = clk ? oe_pair[0]  : oe_pair[1];
  assign line_out = clk ? lvl_pair[0] : lvl_pair[1];
endmodule

// File: rtl/mnrzi_ddr_in.sv
module mnrzi_ddr_in
  import mnrzi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_in,
  input  logic      drv_seen,
  output slot_vec_t lvl_pair,
  output slot_vec_t seen_pair
);
  logic early_lvl_q, early_seen_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_lvl_q  <= 1'b0;
      early_seen_q <= 1'b0;
    end else begin
      early_lvl_q  <= line_in;
      early_seen_q <= drv_seen;
    end
  end

  assign lvl_pair  = {line_in, early_lvl_q};
  assign seen_pair = {drv_seen, early_seen_q};
endmodule

// File: rtl/mnrzi_rx_dec.sv
module mnrzi_rx_dec
  import mnrzi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slot_vec_t lvl_pair,
  input  slot_vec_t seen_pair,
  input  slot_vec_t expect_drv,
  output slot_vec_t bits_q,
  output slot_vec_t undriven_q
);
  logic rx_ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ref_q   <= 1'b0;
      bits_q     <= '0;
      undriven_q <= '0;
    end else begin
      rx_ref_q   <= lvl_pair[SLOTS-1];
      bits_q     <= dec_bits(rx_ref_q, lvl_pair);
      undriven_q <= missing_drv(expect_drv, seen_pair);
    end
  end
endmodule

// File: rtl/mnrzi_ddr_codec.sv
module mnrzi_ddr_codec
  import mnrzi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tx_bits,
  output logic       line_oe,
  output logic       line_out,
  input  logic       line_in,
  input  logic       line_drv_seen,
  input  logic [1:0] rx_expect_drv,
  output logic [1:0] rx_bits,
  output logic [1:0] rx_undriven
);
  slot_vec_t tx_oe_pair, tx_lvl_pair, cap_lvl_pair, cap_seen_pair;

  mnrzi_tx_enc u_enc (
    .clk(clk), .rst_n(rst_n), .bits(tx_bits),
    .oe_q(tx_oe_pair), .lvl_q(tx_lvl_pair)
  );

  mnrzi_ddr_out u_out (
    .clk(clk), .oe_pair(tx_oe_pair), .lvl_pair(tx_lvl_pair),
    .line_oe(line_oe), .line_out(line_out)
  );

  mnrzi_ddr_in u_in (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .drv_seen(line_drv_seen),
    .lvl_pair(cap_lvl_pair), .seen_pair(cap_seen_pair)
  );

  mnrzi_rx_dec u_dec (
    .clk(clk), .rst_n(rst_n), .lvl_pair(cap_lvl_pair), .seen_pair(cap_seen_pair),
    .expect_drv(rx_expect_drv), .bits_q(rx_bits), .undriven_q(rx_undriven)
  );
endmodule

// File: rtl/mnrzi_codec_chk.sv
module mnrzi_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] tx_bits,
  input logic [1:0] tx_oe_pair,
  input logic [1:0] tx_lvl_pair,
  input logic       line_in,
  input logic       line_drv_seen,
  input logic       cap_lvl0,
  input logic       cap_seen0,
  input logic [1:0] rx_expect_drv,
  input logic [1:0] rx_bits,
  input logic [1:0] rx_undriven
);
  // R2 / R5: enables follow the send bits taken at the previous rising edge
  a_r2_enable_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tx_oe_pair == $past(tx_bits));

  // R3: a driven first slot inverts the level left by the previous cycle
  a_r3_one_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && tx_oe_pair[0]) |-> tx_lvl_pair[0] != $past(tx_lvl_pair[1]));

  // R4: an undriven first slot keeps the previous level
  a_r4_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !tx_oe_pair[0]) |-> tx_lvl_pair[0] == $past(tx_lvl_pair[1]));

  // R4: second slot level relative to the first
  a_r4_second_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe_pair[1] ^ (tx_lvl_pair[1] == tx_lvl_pair[0]));

  // R6: second slot bit compares the two captured levels
  a_r6_second_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rx_bits[1] == ($past(line_in) ^ $past(cap_lvl0)));

  // R7: undriven flags from expectation and observed drive
  a_r7_undriven_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rx_undriven ==
      ($past(rx_expect_drv) & ~{$past(line_drv_seen), $past(cap_seen0)}));
endmodule

bind mnrzi_ddr_codec mnrzi_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_bits(tx_bits),
  .tx_oe_pair(tx_oe_pair), .tx_lvl_pair(tx_lvl_pair),
  .line_in(line_in), .line_drv_seen(line_drv_seen),
  .cap_lvl0(cap_lvl_pair[0]), .cap_seen0(cap_seen_pair[0]),
  .rx_expect_drv(rx_expect_drv), .rx_bits(rx_bits), .rx_undriven(rx_undriven)
);

// File: tb/sim_mnrzi_ddr_codec.sv
module sim_mnrzi_ddr_codec;
  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] tx_bits;
  logic       line_oe, line_out;
  logic       line_in, line_drv_seen;
  logic [1:0] rx_expect_drv, rx_bits, rx_undriven;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  logic       tx_ref;
  logic       keep;
  logic       pend;
  logic [1:0] exp_bits, exp_und, hold_mask;

  mnrzi_ddr_codec u0 (
    .clk(clk), .rst_n(rst_n), .tx_bits(tx_bits),
    .line_oe(line_oe), .line_out(line_out),
    .line_in(line_in), .line_drv_seen(line_drv_seen),
    .rx_expect_drv(rx_expect_drv), .rx_bits(rx_bits), .rx_undriven(rx_undriven)
  );

  always #(P/2) clk = ~clk;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, expv, $time);
    end
  endtask

  // kind: 0 undriven, 1 driven with change, 2 driven without change
  task automatic bus_slot(input int idx, input int kind);
    logic nl;
    nl = (kind == 1) ? ~keep : keep;
    exp_bits[idx]  = nl ^ keep;
    hold_mask[idx] = (kind == 2);
    line_in        = nl;
    line_drv_seen  = (kind != 0);
    keep           = nl;
  endtask

  task automatic check_rx();
    if (pend) begin
      chk("R9", {1'b0, rx_bits[0]}, {1'b0, exp_bits[0]});
      chk("R6", rx_bits, exp_bits);
      chk("R7", rx_undriven, exp_und);
      for (int i = 0; i < 2; i++)
        if (hold_mask[i]) chk("R8", {rx_bits[i], rx_undriven[i]}, 2'b00);
    end
  endtask

  // entered at low phase + P/4
  task automatic run_cycle(input logic [1:0] txb, input int k0, input int k1,
                           input logic [1:0] expd);
    logic [1:0] e_oe, e_lvl;
    tx_bits = txb;
    e_oe = txb;
    e_lvl[0] = tx_ref ^ txb[0];
    e_lvl[1] = e_lvl[0] ^ txb[1];
    tx_ref = e_lvl[1];
    @(posedge clk); #(P/4);
    check_rx();
    chk(txb[0] ? "R3" : "R2", {1'b0, line_oe}, {1'b0, e_oe[0]});
    chk("R4", {1'b0, line_out}, {1'b0, e_lvl[0]});
    bus_slot(0, k0);
    @(negedge clk); #(P/4);
    chk("R5", {line_oe, line_out}, {e_oe[1], e_lvl[1]});
    bus_slot(1, k1);
    rx_expect_drv = expd;
    exp_und = expd & ~{k1 != 0, k0 != 0};
    pend = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tx_bits = '0; line_in = 1'b0; line_drv_seen = 1'b0; rx_expect_drv = '0;
    keep = 1'b0; tx_ref = 1'b0; pend = 1'b0;
    exp_bits = '0; exp_und = '0; hold_mask = '0;
    repeat (3) @(negedge clk);
    #(P/4);
    chk("R1", {line_oe, line_out}, 2'b00);
    chk("R1", rx_bits, 2'b00);
    chk("R1", rx_undriven, 2'b00);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // first slot after reset: one drives high, high level reads as 1
    run_cycle(2'b01, 1, 0, 2'b11);
    run_cycle(2'b10, 2, 1, 2'b01);
    run_cycle(2'b11, 0, 2, 2'b10);
    for (int i = 0; i < 1200; i++) begin
      int sel;
      sel = (i * 7) % 36;
      run_cycle(2'(i) ^ 2'(i >> 4), sel % 3, (sel / 3) % 3, 2'(sel / 9));
    end
    @(posedge clk); #(P/4);
    check_rx();
    pend = 1'b0;
    @(negedge clk); #(P/4);
    // reset mid-stream: both references go back to low
    do_reset();
    run_cycle(2'b01, 1, 1, 2'b00);
    run_cycle(2'b00, 0, 0, 2'b00);
    @(posedge clk); #(P/4);
    check_rx();
    chk("R1", {1'b0, line_out}, 2'b01);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule